// File: doc/BRIEF.md
# ECC-Checked OTP Shadow Loader

At wakeup this block fills a bank of volatile shadow registers that covers byte addresses 0x00 to 0x2F. First it writes the hardware default image into every shadow block. It then fetches the one-time-programmable image one 72-bit codeword at a time. Each codeword holds 64 data bits and 8 check bits. The block runs each codeword through a single-error-correct, double-error-detect decoder and decides what to do with that block on its own. A clean block is written unchanged. A block with one flipped bit is corrected and then written. A block that cannot be corrected is not written, so its defaults stay in place.

Two sticky flags record the error classes, one for corrected errors and one for uncorrectable errors. Beside each flag sits a register holding the index of the latest block that raised it, so the host can tell which blocks of the image are damaged. A one-cycle done pulse marks the end of the load.

The controller is a state machine with six states:
- IDLE: waits for `start`.
- FILL: writes one default block per cycle.
- FETCH: issues one OTP read.
- WAIT: holds until the read data is valid.
- APPLY: decodes the word, then commits or withholds the block and logs any error.
- FIN: pulses `done`.

The transitions are:
- IDLE→FILL on `start`.
- FILL→FILL until the last block, then FILL→FETCH.
- FETCH→WAIT.
- WAIT→APPLY on valid.
- APPLY→FETCH while blocks remain, and APPLY→FIN after the last block.
- FIN→IDLE.

Top module: `otp_shadow_loader`

## Requirements
- R1: After reset, `sec_flag`, `ded_flag`, `sec_blk`, `ded_blk` and `done` are 0, and no shadow write or OTP read is issued until `start` is pulsed.
- R2: After `start`, every one of the NUM_BLOCKS (default 6) shadow blocks is written with its slice of DEFAULT_IMAGE (block i takes bits [64i+63:64i]) before the first OTP read request.
- R3: OTP blocks are read in ascending index order 0..NUM_BLOCKS-1, with `otp_rd_addr` equal to the block index. Block i is written at shadow byte address 8*i, and data bits [8k+7:8k] go to byte address 8*i+k.
- R4: The codeword layout is fixed. Position 0 holds even parity over all 72 bits. Positions 1, 2, 4, 8, 16, 32 and 64 hold check bits, where check bit 2^j gives even parity over every position whose index has bit j set. Data bits d0..d63 fill the remaining positions in ascending order.
- R5: A codeword with zero syndrome and even overall parity is written unchanged and changes no flag or index.
- R6: A codeword with one flipped bit at any of the 72 positions, check bits included, is written with the corrected data. It sets `sec_flag`, and `sec_blk` takes that block's index.
- R7: A codeword with two flipped bits is not written, so that block keeps its default. It sets `ded_flag`, and `ded_blk` takes that block's index.
- R8: Each block is judged on its own. Neighbours of an uncorrectable block still load, and several blocks that each carry one error all load correctly.
- R9: When several blocks raise the same flag, the index register holds the highest-indexed (latest processed) one.
- R10: The flags and index registers are sticky. Later loads do not clear them, and only reset does.
- R11: `done` is high for exactly one cycle after the last block is handled, and `start` pulses during a load are ignored.
- R12: Odd overall parity with a syndrome that names no position inside the 72-bit word is treated as uncorrectable, exactly as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request pulse |
| otp_rd_en | output | 1 | OTP read request, one cycle |
| otp_rd_addr | output | IDX_W | OTP block index to read |
| otp_rd_data | input | 72 | Codeword returned by OTP |
| otp_rd_valid | input | 1 | Codeword valid |
| shd_wr_en | output | 1 | Shadow block write strobe |
| shd_wr_addr | output | IDX_W+3 | Shadow byte address of block start |
| shd_wr_data | output | 64 | Shadow block data, byte 0 at lowest address |
| sec_flag | output | 1 | Sticky corrected-error flag |
| ded_flag | output | 1 | Sticky uncorrectable-error flag |
| sec_blk | output | IDX_W | Latest corrected block index |
| ded_blk | output | IDX_W | Latest uncorrectable block index |
| done | output | 1 | Load finished, one-cycle pulse |

## Verification
The load is tried with images that are entirely clean, images where every block carries one flipped bit (including the overall parity position), and images that mix clean, corrected and uncorrectable blocks. These separate correction from mere pass-through and show that a withheld block keeps its default without disturbing its neighbours. A crafted triple flip, whose syndrome points past position 71, separates a decoder that blindly flips a bit from one that withholds the block. Random per-block error kinds, with random read latencies and repeated loads, distinguish latest-index logging and sticky flags from per-run flags. A final reset shows that the sticky state clears.

// File: rtl/otp_ldr_pkg.sv
package otp_ldr_pkg;

    localparam int DATA_W = 64;
    localparam int SYN_W  = 7;
    localparam int CW_W   = DATA_W + SYN_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_FETCH,
        ST_WAIT,
        ST_APPLY,
        ST_FIN
    } ldr_state_e;

endpackage

// File: rtl/otp_secded_dec.sv
module otp_secded_dec
    import otp_ldr_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              corr,
    output logic              unc
);

    logic [SYN_W-1:0] syn;
    logic             par;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) syn = syn ^ SYN_W'(p);
        end
        par   = ^cw;
        fixed = cw;
        corr  = 1'b0;
        unc   = 1'b0;
        if (par) begin
            if (int'(syn) < CW_W) begin
                fixed[syn] = ~fixed[syn];
                corr       = 1'b1;
            end else begin
                unc = 1'b1;
            end
        end else if (syn != '0) begin
            unc = 1'b1;
        end
    end

    always_comb begin
        int k;
        k    = 0;
        data = '0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                data[k] = fixed[p];
                k       = k + 1;
            end
        end
    end

endmodule

// File: rtl/otp_err_log.sv
module otp_err_log #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_sec,
    input  logic             ev_ded,
    input  logic [IDX_W-1:0] ev_idx,
    output logic             sec_flag,
    output logic             ded_flag,
    output logic [IDX_W-1:0] sec_blk,
    output logic [IDX_W-1:0] ded_blk
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_flag <= 1'b0;
            sec_blk  <= '0;
        end else if (ev_valid && ev_sec) begin
            sec_flag <= 1'b1;
            sec_blk  <= ev_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ded_flag <= 1'b0;
            ded_blk  <= '0;
        end else if (ev_valid && ev_ded) begin
            ded_flag <= 1'b1;
            ded_blk  <= ev_idx;
        end
    end

endmodule

// File: rtl/otp_shadow_loader.sv
module otp_shadow_loader
    import otp_ldr_pkg::*;
#(
    parameter int NUM_BLOCKS = 6,
    parameter logic [NUM_BLOCKS*DATA_W-1:0] DEFAULT_IMAGE = {NUM_BLOCKS{64'h3C5A_96E1_0F7D_B248}},
    localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              otp_rd_en,
    output logic [IDX_W-1:0]  otp_rd_addr,
    input  logic [CW_W-1:0]   otp_rd_data,
    input  logic              otp_rd_valid,
    output logic              shd_wr_en,
    output logic [ADDR_W-1:0] shd_wr_addr,
    output logic [DATA_W-1:0] shd_wr_data,
    output logic              sec_flag,
    output logic              ded_flag,
    output logic [IDX_W-1:0]  sec_blk,
    output logic [IDX_W-1:0]  ded_blk,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_BLK = IDX_W'(NUM_BLOCKS - 1);

    ldr_state_e        state_q, state_d;
    logic [IDX_W-1:0]  blk_q, blk_d;
    logic [CW_W-1:0]   word_q;
    logic              capture;

    logic [DATA_W-1:0] dec_data;
    logic              dec_corr;
    logic              dec_unc;
    logic              ev_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
            if (capture) word_q <= otp_rd_data;
        end
    end

    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FILL;
                    blk_d   = '0;
                end
            end
            ST_FILL: begin
                if (blk_q == LAST_BLK) begin
                    state_d = ST_FETCH;
                    blk_d   = '0;
                end else begin
                    blk_d = blk_q + 1'b1;
                end
            end
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT: begin
                if (otp_rd_valid) begin
                    capture = 1'b1;
                    state_d = ST_APPLY;
                end
            end
            ST_APPLY: begin
                if (blk_q == LAST_BLK) begin
                    state_d = ST_FIN;
                end else begin
                    state_d = ST_FETCH;
                    blk_d   = blk_q + 1'b1;
                end
            end
            ST_FIN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        otp_rd_en   = 1'b0;
        otp_rd_addr = blk_q;
        shd_wr_en   = 1'b0;
        shd_wr_addr = {blk_q, 3'b000};
        shd_wr_data = '0;
        ev_valid    = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                shd_wr_en   = 1'b1;
                shd_wr_data = DEFAULT_IMAGE[blk_q*DATA_W +: DATA_W];
            end
            ST_FETCH: otp_rd_en = 1'b1;
            ST_APPLY: begin
                shd_wr_en   = ~dec_unc;
                shd_wr_data = dec_data;
                ev_valid    = 1'b1;
            end
            ST_FIN: done = 1'b1;
            default: ;
        endcase
    end

    otp_secded_dec u_dec (
        .cw   (word_q),
        .data (dec_data),
        .corr (dec_corr),
        .unc  (dec_unc)
    );

    otp_err_log #(.IDX_W(IDX_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_sec   (dec_corr),
        .ev_ded   (dec_unc),
        .ev_idx   (blk_q),
        .sec_flag (sec_flag),
        .ded_flag (ded_flag),
        .sec_blk  (sec_blk),
        .ded_blk  (ded_blk)
    );

endmodule

// File: rtl/otp_loader_chk.sv
module otp_loader_chk #(
    parameter int NUM_BLOCKS = 6,
    parameter int IDX_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             sec_flag,
    input logic             ded_flag,
    input logic             shd_wr_en,
    input logic             otp_rd_en,
    input logic [IDX_W-1:0] otp_rd_addr
);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_sec_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_flag |=> sec_flag);

    p_ded_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ded_flag |=> ded_flag);

    p_ded_withheld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ded_flag) |-> !$past(shd_wr_en));

    p_sec_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_flag) |-> $past(shd_wr_en));

    p_rd_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        otp_rd_en |-> (int'(otp_rd_addr) < NUM_BLOCKS));

    p_rd_wr_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        otp_rd_en |-> !shd_wr_en);

endmodule

bind otp_shadow_loader otp_loader_chk #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .sec_flag   (sec_flag),
    .ded_flag   (ded_flag),
    .shd_wr_en  (shd_wr_en),
    .otp_rd_en  (otp_rd_en),
    .otp_rd_addr(otp_rd_addr)
);

// File: tb/tb_otp_shadow_loader.sv
module tb_otp_shadow_loader;

    localparam int NB    = 6;
    localparam int IW    = 3;
    localparam int AW    = 6;
    localparam int NBYTE = NB * 8;
    localparam logic [NB*64-1:0] DEF_IMG = {
        64'h5555_0000_FFFF_1234, 64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF,
        64'hA5A5_5A5A_C3C3_3C3C, 64'h1111_2222_4444_8888, 64'h7E57_0DE0_F00D_CAFE};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           otp_rd_en;
    logic [IW-1:0]  otp_rd_addr;
    logic [71:0]    otp_rd_data = '0;
    logic           otp_rd_valid = 1'b0;
    logic           shd_wr_en;
    logic [AW-1:0]  shd_wr_addr;
    logic [63:0]    shd_wr_data;
    logic           sec_flag, ded_flag, done;
    logic [IW-1:0]  sec_blk, ded_blk;

    always #2 clk = ~clk;

    otp_shadow_loader #(.NUM_BLOCKS(NB), .DEFAULT_IMAGE(DEF_IMG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .otp_rd_en(otp_rd_en), .otp_rd_addr(otp_rd_addr),
        .otp_rd_data(otp_rd_data), .otp_rd_valid(otp_rd_valid),
        .shd_wr_en(shd_wr_en), .shd_wr_addr(shd_wr_addr), .shd_wr_data(shd_wr_data),
        .sec_flag(sec_flag), .ded_flag(ded_flag),
        .sec_blk(sec_blk), .ded_blk(ded_blk), .done(done));

    int n_tests = 0;
    int n_fail  = 0;

    logic [71:0] otp_mem [NB];
    logic [63:0] blk_data [NB];
    int          blk_kind [NB];
    logic [7:0]  shd_m [NBYTE];

    int  rsp_cnt = 0;
    int  rsp_lat = 1;
    int  pend_idx = 0;
    int  writes_before_rd = 0;
    bit  rd_seen = 0;
    int  next_rd = 0;
    bit  rd_order_ok = 1;
    int  done_cnt = 0;
    int  act_cnt = 0;

    bit          exp_sec = 0, exp_ded = 0;
    logic [IW-1:0] exp_sec_blk = '0, exp_ded_blk = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] encode(input logic [63:0] d);
        logic [71:0] w;
        int k;
        w = '0;
        k = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            logic b;
            b = 1'b0;
            for (int p = 1; p < 72; p++)
                if (((p >> j) & 1) == 1 && p != (1 << j)) b ^= w[p];
            w[1 << j] = b;
        end
        w[0] = ^w[71:1];
        return w;
    endfunction

    always @(negedge clk) begin
        otp_rd_valid = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                otp_rd_valid = 1'b1;
                otp_rd_data  = otp_mem[pend_idx];
            end
        end
        if (otp_rd_en) begin
            pend_idx = int'(otp_rd_addr);
            rsp_cnt  = rsp_lat;
            rd_seen  = 1;
            if (int'(otp_rd_addr) != next_rd) rd_order_ok = 0;
            next_rd++;
        end
        if (shd_wr_en) begin
            if (!rd_seen) writes_before_rd++;
            for (int k = 0; k < 8; k++)
                if (int'(shd_wr_addr) + k < NBYTE) shd_m[int'(shd_wr_addr) + k] = shd_wr_data[8*k +: 8];
        end
        if (done) done_cnt++;
        if (otp_rd_en || shd_wr_en) act_cnt++;
    end

    task automatic build_image();
        for (int b = 0; b < NB; b++) begin
            logic [71:0] w;
            int a, c;
            w = encode(blk_data[b]);
            case (blk_kind[b])
                1: begin
                    a = $urandom_range(0, 71);
                    w[a] = ~w[a];
                end
                2: begin
                    a = $urandom_range(0, 71);
                    c = (a + $urandom_range(1, 71)) % 72;
                    w[a] = ~w[a];
                    w[c] = ~w[c];
                end
                3: begin
                    w[64] = ~w[64];
                    w[8]  = ~w[8];
                    w[1]  = ~w[1];
                end
                4: w[0] = ~w[0];
                default: ;
            endcase
            otp_mem[b] = w;
        end
    endtask

    task automatic run_load(input string tag);
        int guard;
        build_image();
        for (int i = 0; i < NBYTE; i++) shd_m[i] = 8'h00;
        rd_seen = 0;
        writes_before_rd = 0;
        next_rd = 0;
        rd_order_ok = 1;
        done_cnt = 0;
        rsp_lat = $urandom_range(1, 4);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (done_cnt == 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            logic [63:0] got, exp;
            for (int k = 0; k < 8; k++) got[8*k +: 8] = shd_m[8*b + k];
            if (blk_kind[b] == 2 || blk_kind[b] == 3) begin
                exp = DEF_IMG[64*b +: 64];
                exp_ded = 1;
                exp_ded_blk = IW'(b);
            end else begin
                exp = blk_data[b];
                if (blk_kind[b] == 1 || blk_kind[b] == 4) begin
                    exp_sec = 1;
                    exp_sec_blk = IW'(b);
                end
            end
            check(got == exp, $sformatf("R5/R6/R7/R8/R12 %s blk%0d kind%0d", tag, b, blk_kind[b]), got, exp);
        end
        check(writes_before_rd == NB, {"R2 defaults first ", tag}, 64'(writes_before_rd), 64'(NB));
        check(rd_order_ok && next_rd == NB, {"R3 read order ", tag}, 64'(next_rd), 64'(NB));
        check(done_cnt == 1, {"R11 done once ", tag}, 64'(done_cnt), 64'd1);
        check(sec_flag == exp_sec, {"R6/R10 sec_flag ", tag}, 64'(sec_flag), 64'(exp_sec));
        check(ded_flag == exp_ded, {"R7/R10 ded_flag ", tag}, 64'(ded_flag), 64'(exp_ded));
        check(sec_blk == exp_sec_blk, {"R9 sec_blk ", tag}, 64'(sec_blk), 64'(exp_sec_blk));
        check(ded_blk == exp_ded_blk, {"R9 ded_blk ", tag}, 64'(ded_blk), 64'(exp_ded_blk));
    endtask

    task automatic check_defaults_only(input string tag);
        for (int b = 0; b < NB; b++) begin
            logic [63:0] got;
            for (int k = 0; k < 8; k++) got[8*k +: 8] = shd_m[8*b + k];
            check(got == DEF_IMG[64*b +: 64], {"R2 default byte order ", tag}, got, DEF_IMG[64*b +: 64]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        check({sec_flag, ded_flag, done} == 3'b000, "R1 reset flags", 64'({sec_flag, ded_flag, done}), 64'd0);
        check(sec_blk == '0 && ded_blk == '0, "R1 reset indices", 64'({sec_blk, ded_blk}), 64'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(act_cnt == 0, "R1 idle without start", 64'(act_cnt), 64'd0);

        // R4 R5: all clean, walking patterns
        for (int b = 0; b < NB; b++) begin
            blk_data[b] = 64'h1 << (b * 11);
            blk_kind[b] = 0;
        end
        blk_data[0] = 64'h0;
        blk_data[NB-1] = '1;
        run_load("clean");

        // R8: every block carries one error, block 0 on the parity position
        for (int b = 0; b < NB; b++) begin
            blk_data[b] = {$urandom(), $urandom()};
            blk_kind[b] = (b == 0) ? 4 : 1;
        end
        run_load("all-single");

        // R7 R8: double error in the middle, neighbours load
        for (int b = 0; b < NB; b++) begin
            blk_data[b] = {$urandom(), $urandom()};
            blk_kind[b] = 0;
        end
        blk_kind[2] = 2;
        run_load("mid-double");

        // R2: all blocks uncorrectable leave the full default image
        for (int b = 0; b < NB; b++) blk_kind[b] = 2;
        run_load("all-double");
        check_defaults_only("all-double");

        // R12: triple flip with out-of-range syndrome
        for (int b = 0; b < NB; b++) blk_kind[b] = 0;
        blk_kind[4] = 3;
        blk_kind[1] = 1;
        run_load("triple");

        // R9 R10: random mixes, sticky across loads
        for (int r = 0; r < 20; r++) begin
            for (int b = 0; b < NB; b++) begin
                blk_data[b] = {$urandom(), $urandom()};
                blk_kind[b] = $urandom_range(0, 4);
            end
            run_load($sformatf("rand%0d", r));
        end

        // R10: reset clears sticky state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sec_flag && !ded_flag, "R10 flags cleared by reset", 64'({sec_flag, ded_flag}), 64'd0);
        check(sec_blk == '0 && ded_blk == '0, "R10 indices cleared by reset", 64'({sec_blk, ded_blk}), 64'd0);
        exp_sec = 0;
        exp_ded = 0;
        exp_sec_blk = '0;
        exp_ded_blk = '0;
        for (int b = 0; b < NB; b++) blk_kind[b] = 0;
        run_load("after-reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule